// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the serial test port of a memory device. A test clock and a mode-select line drive the standard sixteen-state controller. The controller routes a serial input through one of four shift paths and back out on a serial output. The paths are a 3-bit instruction register, a 1-bit bypass stage, a 32-bit identification word and a 108-position boundary chain. The boundary chain captures a parallel vector of sampled pin levels and shifts it out. It never drives anything back into the device.

There is no dedicated test-reset pin. The asynchronous power-on reset puts the controller in its reset state, where the identification instruction is active. The block also raises a force-high-impedance request for the device's read-data outputs while either of the two pin-sampling instructions that isolate the outputs is in effect. A board-level pull-up on the mode-select line is assumed, so an idle line reads as 1 and returns the port to reset.

Top module: `bscan_port`

## Requirements
- R1: After power-on reset the serial output enable is 0, the high-impedance request is 0, and a data-register scan returns the identification word.
- R2: Five consecutive TCK rising edges with TMS at 1 bring the controller to its reset state from any state; this makes IDCODE (001) the active instruction again and releases the high-impedance request.
- R3: In Capture-IR the instruction shift register loads binary 001, which the serial output presents least significant bit first as 1, 0, 0.
- R4: The identification word is, from bit 31 down, a 3-bit revision 000, a 17-bit configuration field (parameter, default 0x0A5C3), the 11-bit vendor code 00001001110, and a 1 in bit 0; it is shifted out bit 0 first.
- R5: Under instruction 111 the 1-bit bypass stage captures 0 in Capture-DR and then delays the serial input by one shift.
- R6: The unassigned codes 011, 101 and 110 select the bypass stage exactly as 111 does.
- R7: Instruction 100 captures the pin vector into the boundary chain and leaves the high-impedance request at 0.
- R8: Instructions 000 and 010 capture the pin vector into the boundary chain, and the high-impedance request is 1 from the update of either instruction until another instruction is loaded or the controller resets.
- R9: The boundary chain is 108 positions long: pin bit 0 leaves first, and a bit entering on TDI reappears on TDO after 108 shifts.
- R10: TDO and its enable change only on falling TCK edges, and the enable is 1 only while the controller is in Shift-DR or Shift-IR.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| rstN | input | 1 | Asynchronous power-on reset, active low |
| tms | input | 1 | Test mode select, sampled on rising TCK |
| tdi | input | 1 | Serial test data in, sampled on rising TCK |
| pinSample | input | 108 | Parallel sampled pin levels captured by the boundary chain |
| tdo | output | 1 | Serial test data out, launched on falling TCK |
| tdoEn | output | 1 | Enable for the serial output driver |
| dqHighZ | output | 1 | Request to place the device's read-data outputs in high impedance |

## Verification
On every cycle the assertions check several things. The reset state reloads the identification instruction, and Capture-IR leaves 001 in the instruction shifter. Five ones on TMS always land in reset. The bypass and identification captures take their values, and the boundary chain takes the pin vector seen at capture. The output enable is never high outside a shift state, and the high-impedance request only rises straight after Update-IR. The bench scenarios show the serial bit order of each path end to end. They show the 108-shift latency of the chain, the one-shift delay of bypass under the assigned and the unassigned codes, and that the high-impedance request lasts across data scans and falls on a TMS-driven reset.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

  localparam int IR_W = 3;

  localparam logic [IR_W-1:0] INS_EXTEST  = 3'b000;
  localparam logic [IR_W-1:0] INS_IDCODE  = 3'b001;
  localparam logic [IR_W-1:0] INS_SAMPLEZ = 3'b010;
  localparam logic [IR_W-1:0] INS_SAMPLE  = 3'b100;
  localparam logic [IR_W-1:0] INS_BYPASS  = 3'b111;
  localparam logic [IR_W-1:0] IR_CAPTURE  = 3'b001;

  localparam int REV_W    = 3;
  localparam int VENDOR_W = 11;
  localparam logic [REV_W-1:0]    ID_REVISION = 3'b000;
  localparam logic [VENDOR_W-1:0] ID_VENDOR   = 11'b00001001110;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_SEL_DR, ST_CAP_DR, ST_SHIFT_DR, ST_EXIT1_DR, ST_PAUSE_DR, ST_EXIT2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SHIFT_IR, ST_EXIT1_IR, ST_PAUSE_IR, ST_EXIT2_IR, ST_UPD_IR
  } tapState_t;

  typedef struct packed {
    logic captureDr;
    logic shiftDr;
    logic shiftIr;
    logic selBypass;
    logic selId;
    logic selBsr;
    logic irTdo;
  } scanStrobe_t;

endpackage

// File: rtl/bscan_ctrl.sv
module bscan_ctrl
  import bscan_pkg::*;
(
  input  logic        tck,
  input  logic        rstN,
  input  logic        tms,
  input  logic        tdi,
  output scanStrobe_t strb,
  output logic        dqHighZ
);

  tapState_t state, nextState;
  logic [IR_W-1:0] irShift;
  logic [IR_W-1:0] irReg;

  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN) state <= ST_RESET;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    case (state)
      ST_RESET:    nextState = tms ? ST_RESET    : ST_IDLE;
      ST_IDLE:     nextState = tms ? ST_SEL_DR   : ST_IDLE;
      ST_SEL_DR:   nextState = tms ? ST_SEL_IR   : ST_CAP_DR;
      ST_CAP_DR:   nextState = tms ? ST_EXIT1_DR : ST_SHIFT_DR;
      ST_SHIFT_DR: nextState = tms ? ST_EXIT1_DR : ST_SHIFT_DR;
      ST_EXIT1_DR: nextState = tms ? ST_UPD_DR   : ST_PAUSE_DR;
      ST_PAUSE_DR: nextState = tms ? ST_EXIT2_DR : ST_PAUSE_DR;
      ST_EXIT2_DR: nextState = tms ? ST_UPD_DR   : ST_SHIFT_DR;
      ST_UPD_DR:   nextState = tms ? ST_SEL_DR   : ST_IDLE;
      ST_SEL_IR:   nextState = tms ? ST_RESET    : ST_CAP_IR;
      ST_CAP_IR:   nextState = tms ? ST_EXIT1_IR : ST_SHIFT_IR;
      ST_SHIFT_IR: nextState = tms ? ST_EXIT1_IR : ST_SHIFT_IR;
      ST_EXIT1_IR: nextState = tms ? ST_UPD_IR   : ST_PAUSE_IR;
      ST_PAUSE_IR: nextState = tms ? ST_EXIT2_IR : ST_PAUSE_IR;
      ST_EXIT2_IR: nextState = tms ? ST_UPD_IR   : ST_SHIFT_IR;
      ST_UPD_IR:   nextState = tms ? ST_SEL_DR   : ST_IDLE;
      default:     nextState = ST_RESET;
    endcase
  end

  // instruction shifter: capture fixed pattern, shift toward bit 0
  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN) begin
      irShift <= '0;
    end else if (state == ST_CAP_IR) begin
      irShift <= IR_CAPTURE;
    end else if (state == ST_SHIFT_IR) begin
      irShift <= {tdi, irShift[IR_W-1:1]};
    end
  end

  // active instruction
  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN)                  irReg <= INS_IDCODE;
    else if (state == ST_RESET) irReg <= INS_IDCODE;
    else if (state == ST_UPD_IR) irReg <= irShift;
  end

  always_comb begin
    strb           = '0;
    strb.captureDr = (state == ST_CAP_DR);
    strb.shiftDr   = (state == ST_SHIFT_DR);
    strb.shiftIr   = (state == ST_SHIFT_IR);
    strb.irTdo     = irShift[0];
    case (irReg)
      INS_IDCODE:                          strb.selId  = 1'b1;
      INS_EXTEST, INS_SAMPLEZ, INS_SAMPLE: strb.selBsr = 1'b1;
      default:                             strb.selBypass = 1'b1;
    endcase
  end

  assign dqHighZ = (irReg == INS_EXTEST) || (irReg == INS_SAMPLEZ);

  a_r2_reset_state_loads_idcode: assert property (@(posedge tck) disable iff (!rstN)
    (state == ST_RESET) |=> (irReg == INS_IDCODE));

  a_r3_capture_ir_pattern: assert property (@(posedge tck) disable iff (!rstN)
    (state == ST_CAP_IR) |=> (irShift == 3'b001));

  a_r2_five_ones_reach_reset: assert property (@(posedge tck) disable iff (!rstN)
    ($past(tms, 1) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4) && $past(tms, 5))
      |-> (state == ST_RESET));

  a_r8_highz_rises_after_update: assert property (@(posedge tck) disable iff (!rstN)
    $rose(dqHighZ) |-> ($past(state) == ST_UPD_IR));

endmodule

// File: rtl/bscan_dp.sv
module bscan_dp
  import bscan_pkg::*;
#(
  parameter int BSR_LEN = 108,
  parameter int CFG_W   = 17,
  parameter logic [CFG_W-1:0] PART_CFG = 17'h0A5C3
) (
  input  logic               tck,
  input  logic               rstN,
  input  logic               tdi,
  input  logic [BSR_LEN-1:0] pinSample,
  input  scanStrobe_t        strb,
  output logic               tdo,
  output logic               tdoEn
);

  localparam int ID_W = REV_W + CFG_W + VENDOR_W + 1;
  localparam logic [ID_W-1:0] ID_VALUE = {ID_REVISION, PART_CFG, ID_VENDOR, 1'b1};

  logic              bypassReg;
  logic [ID_W-1:0]   idShift;
  logic [BSR_LEN-1:0] bsr;
  logic              drBit;

  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN) begin
      bypassReg <= 1'b0;
    end else if (strb.selBypass) begin
      if (strb.captureDr)    bypassReg <= 1'b0;
      else if (strb.shiftDr) bypassReg <= tdi;
    end
  end

  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN) begin
      idShift <= '0;
    end else if (strb.selId) begin
      if (strb.captureDr)    idShift <= ID_VALUE;
      else if (strb.shiftDr) idShift <= {tdi, idShift[ID_W-1:1]};
    end
  end

  // boundary chain, one cell per sampled pin
  for (genvar i = 0; i < BSR_LEN; i++) begin : g_cell
    logic shiftIn;
    if (i == BSR_LEN - 1) begin : g_head
      assign shiftIn = tdi;
    end else begin : g_body
      assign shiftIn = bsr[i+1];
    end
    always_ff @(posedge tck or negedge rstN) begin
      if (!rstN) begin
        bsr[i] <= 1'b0;
      end else if (strb.selBsr) begin
        if (strb.captureDr)    bsr[i] <= pinSample[i];
        else if (strb.shiftDr) bsr[i] <= shiftIn;
      end
    end
  end

  always_comb begin
    if (strb.selBypass)  drBit = bypassReg;
    else if (strb.selId) drBit = idShift[0];
    else                 drBit = bsr[0];
  end

  always_ff @(negedge tck or negedge rstN) begin
    if (!rstN) begin
      tdo   <= 1'b0;
      tdoEn <= 1'b0;
    end else begin
      tdo   <= strb.shiftIr ? strb.irTdo : drBit;
      tdoEn <= strb.shiftDr | strb.shiftIr;
    end
  end

  a_r5_bypass_captures_zero: assert property (@(posedge tck) disable iff (!rstN)
    (strb.captureDr && strb.selBypass) |=> (bypassReg == 1'b0));

  a_r4_id_capture: assert property (@(posedge tck) disable iff (!rstN)
    (strb.captureDr && strb.selId) |=> (idShift == ID_VALUE));

  a_r9_chain_takes_pins: assert property (@(posedge tck) disable iff (!rstN)
    (strb.captureDr && strb.selBsr) |=> (bsr == $past(pinSample)));

  a_r10_enable_only_in_shift: assert property (@(posedge tck) disable iff (!rstN)
    tdoEn |-> (strb.shiftDr || strb.shiftIr));

endmodule

// File: rtl/bscan_port.sv
module bscan_port
  import bscan_pkg::*;
#(
  parameter int BSR_LEN = 108,
  parameter int CFG_W   = 17,
  parameter logic [CFG_W-1:0] PART_CFG = 17'h0A5C3
) (
  input  logic               tck,
  input  logic               rstN,
  input  logic               tms,
  input  logic               tdi,
  input  logic [BSR_LEN-1:0] pinSample,
  output logic               tdo,
  output logic               tdoEn,
  output logic               dqHighZ
);

  scanStrobe_t strb;

  bscan_ctrl u_ctrl (
    .tck     (tck),
    .rstN    (rstN),
    .tms     (tms),
    .tdi     (tdi),
    .strb    (strb),
    .dqHighZ (dqHighZ)
  );

  bscan_dp #(
    .BSR_LEN  (BSR_LEN),
    .CFG_W    (CFG_W),
    .PART_CFG (PART_CFG)
  ) u_dp (
    .tck       (tck),
    .rstN      (rstN),
    .tdi       (tdi),
    .pinSample (pinSample),
    .strb      (strb),
    .tdo       (tdo),
    .tdoEn     (tdoEn)
  );

endmodule

// File: tb/bscan_port_bench.sv
module bscan_port_bench;

  localparam int BSR_LEN = 108;
  localparam logic [31:0] EXP_ID = {3'b000, 17'h0A5C3, 11'b00001001110, 1'b1};

  logic tck = 1'b0;
  logic rstN = 1'b0;
  logic tms = 1'b1;
  logic tdi = 1'b1;
  logic [BSR_LEN-1:0] pinSample = '0;
  logic tdo, tdoEn, dqHighZ;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  logic expBit[$];
  string expTag[$];

  always #10 tck = ~tck;

  bscan_port #(.BSR_LEN(BSR_LEN), .CFG_W(17), .PART_CFG(17'h0A5C3)) u_bscan_port (
    .tck(tck), .rstN(rstN), .tms(tms), .tdi(tdi), .pinSample(pinSample),
    .tdo(tdo), .tdoEn(tdoEn), .dqHighZ(dqHighZ)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // monitor: every enabled serial bit is compared with the next queued item
  always @(negedge tck) begin
    #2;
    if (tdoEn === 1'b1) begin
      compared++;
      if (expBit.size() == 0) begin
        mismatched++;
        $display("FAIL R10: actual tdoEn 1 expected 0 (no shift pending)");
      end else begin
        logic e;
        string t;
        e = expBit.pop_front();
        t = expTag.pop_front();
        if (tdo !== e) begin
          mismatched++;
          $display("FAIL %s: actual tdo %b expected %b", t, tdo, e);
        end
      end
    end
  end

  task automatic tick(input logic m, input logic d);
    tms = m;
    tdi = d;
    @(posedge tck);
    @(negedge tck);
    #1;
  endtask

  task automatic scanIr(input logic [2:0] ins);
    for (int i = 0; i < 3; i++) begin
      expBit.push_back(i == 0);
      expTag.push_back("R3");
    end
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < 3; i++) tick(i == 2, ins[i]);
    tick(1, 0); tick(0, 0);
  endtask

  task automatic scanDr(input int n, input logic [127:0] din,
                        input logic [127:0] dexp, input string tag);
    for (int i = 0; i < n; i++) begin
      expBit.push_back(dexp[i]);
      expTag.push_back(tag);
    end
    tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < n; i++) tick(i == n - 1, din[i]);
    tick(1, 0); tick(0, 0);
  endtask

  task automatic bypassScan(input string tag);
    logic [127:0] din, dexp;
    din = 128'hB2;
    dexp = '0;
    for (int i = 1; i < 8; i++) dexp[i] = din[i-1];
    scanDr(8, din, dexp, tag);
  endtask

  task automatic chainScan(input int n, input logic [127:0] din, input string tag);
    logic [127:0] dexp;
    dexp = '0;
    for (int i = 0; i < n; i++) dexp[i] = (i < BSR_LEN) ? pinSample[i] : din[i-BSR_LEN];
    scanDr(n, din, dexp, tag);
  endtask

  initial begin
    for (int i = 0; i < BSR_LEN; i++) pinSample[i] = ((i * 7 + 3) % 5) < 2;
    repeat (3) @(negedge tck);
    #1 rstN = 1'b1;

    check("R1 tdoEn after reset", tdoEn, 1'b0);
    check("R1 dqHighZ after reset", dqHighZ, 1'b0);
    tick(0, 0);
    check("R10 tdoEn in idle", tdoEn, 1'b0);
    scanDr(32, {128{1'b1}}, {96'd0, EXP_ID}, "R1 R4 identification");

    scanIr(3'b111);
    check("R10 tdoEn after IR scan", tdoEn, 1'b0);
    bypassScan("R5 bypass 111");

    scanIr(3'b011); bypassScan("R6 code 011");
    scanIr(3'b101); bypassScan("R6 code 101");
    scanIr(3'b110); bypassScan("R6 code 110");

    scanIr(3'b100);
    check("R7 SAMPLE keeps outputs", dqHighZ, 1'b0);
    chainScan(116, 128'hC3, "R7 R9 sample chain");

    pinSample = ~pinSample;
    scanIr(3'b010);
    check("R8 SAMPLE-Z forces high-Z", dqHighZ, 1'b1);
    chainScan(BSR_LEN, '0, "R8 sample-z chain");
    check("R8 high-Z held across scan", dqHighZ, 1'b1);

    pinSample = {4{27'h5A3C1E7}};
    scanIr(3'b000);
    check("R8 EXTEST forces high-Z", dqHighZ, 1'b1);
    chainScan(112, 128'h9, "R8 R9 extest chain");

    for (int i = 0; i < 5; i++) tick(1, 0);
    check("R2 high-Z released by reset", dqHighZ, 1'b0);
    tick(0, 0);
    scanDr(32, '0, {96'd0, EXP_ID}, "R2 R4 idcode after reset");

    scanIr(3'b100);
    check("R7 SAMPLE clears high-Z", dqHighZ, 1'b0);
    check("R10 queue drained", expBit.size() == 0, 1'b1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge tck);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule